// File: doc/BRIEF.md
# Timer Global Status and Enable Register

This block is one 16-bit control and status word that serves three general-purpose timers. It records two kinds of timer event for each timer: an interrupt request and a counter-overflow error. Each event is held in a sticky flag, and software clears a flag by writing a one to its position. The block also holds one run-enable flag per timer. Each enable is driven by its own pair of bits, one that sets it and one that clears it. This lets software start or stop one timer without a read-modify-write of the whole word.

The register has no address. An external decoder asserts `sel` when this word is the target of a bus access. A write takes effect only on a clock edge where both `sel` and `wr_en` are high. The read word is always valid. It is built from the current state and shows each timer's enable on both bits of that timer's pair. The combined interrupt output stays high while any interrupt flag is set, so software must clear a flag before the request stops.

Top module: `tmr_gstat`

## Requirements
- R1: When `rst` is high at a clock edge, all interrupt flags, overflow flags and enables become zero, so `rd_data` reads 0x0000, `tmr_en` reads 0 and `irq_out` is low.
- R2: A high `irq_evt[i]` at a clock edge sets interrupt flag i, which reads at bit i (i = 0..2). The flag then stays set after the event input returns low.
- R3: An accepted write with a one at bit i (i = 0..2) clears interrupt flag i. Bits written as zero leave their flags unchanged.
- R4: Overflow flag i reads at bit 4+i. A high `ovf_evt[i]` sets it, the flag is sticky, and an accepted write with a one at bit 4+i clears it.
- R5: When an event and a clearing write reach the same sticky flag on the same edge, the flag ends up set.
- R6: An accepted write with a one at bit 8+2i and a zero at bit 9+2i sets the enable of timer i. A one at bit 9+2i with a zero at bit 8+2i clears it. With both bits zero the enable is unchanged.
- R7: An accepted write with ones at both bit 8+2i and bit 9+2i leaves the enable of timer i cleared.
- R8: `rd_data` shows the enable of timer i at both bit 8+2i and bit 9+2i, and `tmr_en[i]` equals that enable.
- R9: Bits 3, 7, 14 and 15 of `rd_data` always read zero, whatever was written to them.
- R10: `irq_out` is high exactly when at least one of the three interrupt flags is set. Overflow flags do not drive it.
- R11: A write strobe while `sel` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | The access is addressed to this word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current status word |
| irq_evt | input | 3 | Per-timer interrupt event pulses |
| ovf_evt | input | 3 | Per-timer counter-overflow event pulses |
| tmr_en | output | 3 | Per-timer run enables |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The clocked properties assume that `sel`, `wr_en`, `wr_data` and the event inputs are settled before each rising edge. They also assume that an event input held high for several edges means the same thing as repeated events. The bench changes every input only on the falling clock edge, so each value holds for a whole cycle before the rising edge that samples it. The bench sweeps every mix of prior state, event and clearing write for each flag, and every set/clear combination from both enable states. It then runs a long pseudo-random sequence in which unselected strobes, reserved-bit writes and collisions occur mixed together.

// File: rtl/tmr_gstat_pkg.sv
package tmr_gstat_pkg;

    localparam int NUM_TMR = 3;
    localparam int WORD_W  = 16;
    localparam int IRQ_LSB = 0;
    localparam int OVF_LSB = 4;
    localparam int EN_LSB  = 8;

    typedef enum logic [1:0] {
        EN_HOLD  = 2'd0,
        EN_SET   = 2'd1,
        EN_CLEAR = 2'd2
    } en_op_t;

    typedef struct packed {
        logic [NUM_TMR-1:0] irq;
        logic [NUM_TMR-1:0] ovf;
        logic [NUM_TMR-1:0] en;
    } tmr_state_t;

    // Clear requests for a contiguous field of sticky bits.
    function automatic logic [NUM_TMR-1:0] field_bits(
        input logic [WORD_W-1:0] word,
        input int                lsb
    );
        logic [NUM_TMR-1:0] r;
        for (int i = 0; i < NUM_TMR; i++) r[i] = word[lsb + i];
        return r;
    endfunction

    // Clear has priority over set within one enable pair.
    function automatic en_op_t decode_en_op(
        input logic            acc,
        input logic [WORD_W-1:0] word,
        input int              tmr
    );
        if (!acc)                          return EN_HOLD;
        if (word[EN_LSB + 2*tmr + 1])      return EN_CLEAR;
        if (word[EN_LSB + 2*tmr])          return EN_SET;
        return EN_HOLD;
    endfunction

    function automatic logic [WORD_W-1:0] pack_word(input tmr_state_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            w[IRQ_LSB + i]        = s.irq[i];
            w[OVF_LSB + i]        = s.ovf[i];
            w[EN_LSB + 2*i]       = s.en[i];
            w[EN_LSB + 2*i + 1]   = s.en[i];
        end
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] reserved_mask();
        logic [WORD_W-1:0] m;
        m = '1;
        for (int i = 0; i < NUM_TMR; i++) begin
            m[IRQ_LSB + i]      = 1'b0;
            m[OVF_LSB + i]      = 1'b0;
            m[EN_LSB + 2*i]     = 1'b0;
            m[EN_LSB + 2*i + 1] = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/tmr_sticky_bank.sv
module tmr_sticky_bank #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_evt,
    input  logic [W-1:0] clr_req,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)             q[i] <= 1'b0;
            else if (set_evt[i]) q[i] <= 1'b1;
            else if (clr_req[i]) q[i] <= 1'b0;
        end

        // R2 / R4: a set flag survives until a clear request
        a_r2_sticky_hold: assert property (@(posedge clk) disable iff (rst)
            (q[i] && !clr_req[i]) |=> q[i]);
        // R5: an event always lands, even against a clear
        a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_evt[i] |=> q[i]);
        // R3 / R4: an uncontested clear removes the flag
        a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
            (clr_req[i] && !set_evt[i]) |=> !q[i]);
    end

endmodule

// File: rtl/tmr_enable_cell.sv
module tmr_enable_cell
    import tmr_gstat_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  en_op_t op,
    output logic   en
);

    always_ff @(posedge clk) begin
        if (rst) en <= 1'b0;
        else begin
            unique case (op)
                EN_SET:   en <= 1'b1;
                EN_CLEAR: en <= 1'b0;
                default:  en <= en;
            endcase
        end
    end

    // R6: hold leaves the enable unchanged
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (op == EN_HOLD) |=> $stable(en));

endmodule

// File: rtl/tmr_gstat.sv
module tmr_gstat
    import tmr_gstat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   rd_data,
    input  logic [NUM_TMR-1:0]  irq_evt,
    input  logic [NUM_TMR-1:0]  ovf_evt,
    output logic [NUM_TMR-1:0]  tmr_en,
    output logic                irq_out
);

    localparam logic [WORD_W-1:0] RSV_MASK = reserved_mask();

    logic               acc;
    logic [NUM_TMR-1:0] irq_clr;
    logic [NUM_TMR-1:0] ovf_clr;
    tmr_state_t         st;

    assign acc     = sel & wr_en;
    assign irq_clr = acc ? field_bits(wr_data, IRQ_LSB) : '0;
    assign ovf_clr = acc ? field_bits(wr_data, OVF_LSB) : '0;

    tmr_sticky_bank #(.W(NUM_TMR)) i_irq_bank (
        .clk     (clk),
        .rst     (rst),
        .set_evt (irq_evt),
        .clr_req (irq_clr),
        .q       (st.irq)
    );

    tmr_sticky_bank #(.W(NUM_TMR)) i_ovf_bank (
        .clk     (clk),
        .rst     (rst),
        .set_evt (ovf_evt),
        .clr_req (ovf_clr),
        .q       (st.ovf)
    );

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        en_op_t op;
        assign op = decode_en_op(acc, wr_data, t);

        tmr_enable_cell i_en (
            .clk (clk),
            .rst (rst),
            .op  (op),
            .en  (st.en[t])
        );

        // R7: clear bit dominates any set bit in the same write
        a_r7_clear_priority: assert property (@(posedge clk) disable iff (rst)
            (acc && wr_data[EN_LSB + 2*t + 1]) |=> !tmr_en[t]);
        // R6: a lone set bit turns the timer on
        a_r6_set_only: assert property (@(posedge clk) disable iff (rst)
            (acc && wr_data[EN_LSB + 2*t] && !wr_data[EN_LSB + 2*t + 1]) |=> tmr_en[t]);
        // R8: the enable output matches the upper bit of its read pair
        a_r8_pair_mirror: assert property (@(posedge clk) disable iff (rst)
            tmr_en[t] == rd_data[EN_LSB + 2*t + 1]);
    end

    assign rd_data = pack_word(st);
    assign tmr_en  = st.en;
    assign irq_out = |st.irq;

    // R9: reserved positions never read as one
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data & RSV_MASK) == '0);
    // R11: without an accepted write or any event the word does not move
    a_r11_no_access_stable: assert property (@(posedge clk) disable iff (rst)
        (!acc && !(|irq_evt) && !(|ovf_evt)) |=> $stable(rd_data));
    // R1: reset empties the whole word
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

endmodule

// File: tb/test_tmr_gstat.sv
`timescale 1ns/1ps
module test_tmr_gstat;
    import tmr_gstat_pkg::*;

    logic               clk = 1'b0;
    logic               rst;
    logic               sel;
    logic               wr_en;
    logic [15:0]        wr_data;
    logic [15:0]        rd_data;
    logic [2:0]         irq_evt;
    logic [2:0]         ovf_evt;
    logic [2:0]         tmr_en;
    logic               irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic [2:0] m_irq, m_ovf, m_en;

    always #10 clk = ~clk;

    tmr_gstat i_tmr_gstat (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq_evt(irq_evt), .ovf_evt(ovf_evt),
        .tmr_en(tmr_en), .irq_out(irq_out)
    );

    function automatic logic [15:0] exp_word();
        logic [15:0] w = 16'h0000;
        for (int i = 0; i < 3; i++) begin
            w[i]       = m_irq[i];
            w[4+i]     = m_ovf[i];
            w[8+2*i]   = m_en[i];
            w[9+2*i]   = m_en[i];
        end
        return w;
    endfunction

    task automatic check(input string req);
        logic [15:0] ew = exp_word();
        n_chk++;
        if (rd_data !== ew || tmr_en !== m_en || irq_out !== (|m_irq)) begin
            n_fail++;
            $display("FAIL %s: rd=%h en=%b irq=%b expected rd=%h en=%b irq=%b",
                     req, rd_data, tmr_en, irq_out, ew, m_en, |m_irq);
        end
    endtask

    // One cycle: drive on the falling edge, model at the rising edge, check on the next fall
    task automatic step(input logic s, input logic w, input logic [15:0] d,
                        input logic [2:0] ie, input logic [2:0] oe, input string req);
        logic acc;
        @(negedge clk);
        sel = s; wr_en = w; wr_data = d; irq_evt = ie; ovf_evt = oe;
        @(posedge clk);
        acc = s & w;
        m_irq = (m_irq & ~(acc ? d[2:0] : 3'b000)) | ie;
        m_ovf = (m_ovf & ~(acc ? d[6:4] : 3'b000)) | oe;
        for (int i = 0; i < 3; i++) begin
            if (acc && d[9+2*i])      m_en[i] = 1'b0;
            else if (acc && d[8+2*i]) m_en[i] = 1'b1;
        end
        @(negedge clk);
        sel = 0; wr_en = 0; wr_data = 0; irq_evt = 0; ovf_evt = 0;
        check(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        m_irq = 0; m_ovf = 0; m_en = 0;
        @(negedge clk);
        rst = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: rd=%h expected completion", rd_data);
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1; sel = 0; wr_en = 0; wr_data = 0; irq_evt = 0; ovf_evt = 0;
        m_irq = 0; m_ovf = 0; m_en = 0;
        repeat (2) @(posedge clk);
        do_reset();
        check("R1");

        // R2 R3 R4 R5: every (prior, event, clear) mix on every sticky flag
        for (int f = 0; f < 6; f++) begin
            for (int c = 0; c < 8; c++) begin
                logic [2:0] one = 3'b001 << (f % 3);
                logic       ovf = (f >= 3);
                logic [15:0] clrw = ovf ? {9'b0, one, 4'b0} : {13'b0, one};
                if (c[0]) step(0, 0, 0, ovf ? 3'b0 : one, ovf ? one : 3'b0, ovf ? "R4" : "R2");
                else      step(1, 1, clrw, 0, 0, ovf ? "R4" : "R3");
                step(0, 0, 0, 0, 0, "R2");
                step(1, 1, c[2] ? clrw : 16'h0, c[1] ? (ovf ? 3'b0 : one) : 3'b0,
                     c[1] ? (ovf ? one : 3'b0) : 3'b0, (c[1] && c[2]) ? "R5" : "R3");
            end
        end

        // R6 R7 R8: every set/clear pair from both prior enable states
        for (int t = 0; t < 3; t++) begin
            for (int c = 0; c < 8; c++) begin
                step(1, 1, c[0] ? (16'h0100 << (2*t)) : (16'h0200 << (2*t)), 0, 0, "R6");
                step(1, 1, {14'b0, c[2:1]} << (8 + 2*t), 0, 0,
                     (c[2:1] == 2'b11) ? "R7" : "R8");
            end
        end

        // R9: writes to reserved bits do nothing visible
        step(1, 1, 16'hC088, 0, 0, "R9");
        // R10: overflow flags alone keep irq_out low
        step(0, 0, 0, 0, 3'b111, "R10");
        step(0, 0, 0, 3'b100, 0, "R10");
        // R11: unselected strobe is ignored
        step(0, 1, 16'hFFFF, 0, 0, "R11");
        step(1, 0, 16'hFFFF, 0, 0, "R11");

        // Mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1] | lfsr[2], {lfsr[7:0], lfsr[15:8]} ^ 16'h5A5A,
                 lfsr[10:8] & {3{lfsr[3]}}, lfsr[13:11] & {3{lfsr[4]}},
                 lfsr[0] ? "R5" : "R11");
        end

        // R1: reset from a busy state
        step(1, 1, 16'h1500, 3'b111, 3'b111, "R6");
        do_reset();
        check("R1");
        finish_run();
    end

endmodule